// File: doc/BRIEF.md
# Detent-Scaled Up/Down Digit Counter

This block turns the single-cycle direction pulses from a quadrature wheel decoder into a 4-bit digit. The decoder produces four pulses for every mechanical detent of the wheel. The block therefore holds a small signed pending tally of pulses. It moves the visible digit by one only when that tally reaches a full detent's worth of pulses in one direction.

An up pulse raises the tally and a down pulse lowers it. A pulse against the direction already pending therefore cancels an earlier pulse instead of adding to it. When the tally reaches plus or minus four, the visible digit steps by one in that direction and the tally returns to zero. The digit wraps modulo 16 in both directions.

The block has two parts. A control part owns the pending tally and sends step strobes through a small struct. A datapath part owns the visible digit register.

Top module: `detent_counter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `count` to 0 and clears the pending tally. After reset, the first step therefore needs four same-direction pulses.
- R2: Four `incPulse` pulses with no opposing pulse between them raise `count` by one. The new value is visible right after the clock edge that samples the fourth pulse.
- R3: Four `decPulse` pulses with no opposing pulse between them lower `count` by one. The new value is visible right after the edge that samples the fourth pulse.
- R4: Fewer than four net pulses in one direction leave `count` unchanged.
- R5: A pulse against the pending direction cancels one pending pulse. For example, three up pulses followed by one down pulse leave two up pulses pending.
- R6: Stepping up from 15 gives 0.
- R7: Stepping down from 0 gives 15.
- R8: In a cycle where `incPulse` and `decPulse` are both high, neither `count` nor the pending tally changes.
- R9: Idle cycles between pulses have no effect on the tally. The pulses of a detent need not be in consecutive cycles.
- R10: A reset during a partial accumulation discards the pulses that were pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| incPulse | input | 1 | One-cycle up pulse from the quadrature decoder |
| decPulse | input | 1 | One-cycle down pulse from the quadrature decoder |
| count | output | 4 | Visible digit |

## Verification
Every result of this block is due at the first clock edge that samples the pulse causing it. The step strobe is combinational from the pending tally and the inputs, and only the digit register lies between that strobe and `count`. The bench drives each pulse on a falling edge and holds it for one cycle. It samples `count` on the next falling edge, after exactly one rising edge. Partial-detent, cancelling and both-high cases are checked at that same point. Each of these cases is followed by the remaining pulses of a detent, so the hidden tally is observed through the cycle in which `count` moves.

// File: rtl/detent_counter_pkg.sv
package detent_counter_pkg;
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } stepStrobes_t;
endpackage

// File: rtl/detent_counter_ctrl.sv
module detent_counter_ctrl
  import detent_counter_pkg::*;
#(
  parameter int PULSES_PER_STEP = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         incPulse,
  input  logic         decPulse,
  output stepStrobes_t strobes
);
  localparam int SUB_W = $clog2(PULSES_PER_STEP) + 1;
  localparam logic signed [SUB_W-1:0] SUB_MAX = SUB_W'(PULSES_PER_STEP - 1);
  localparam logic signed [SUB_W-1:0] SUB_MIN = -SUB_MAX;
  localparam logic signed [SUB_W-1:0] SUB_ONE = SUB_W'(1);

  logic signed [SUB_W-1:0] pending;
  logic signed [SUB_W-1:0] pendingNext;
  logic upOnly;
  logic downOnly;

  assign upOnly   = incPulse && !decPulse;
  assign downOnly = decPulse && !incPulse;

  always_comb begin
    strobes.stepUp   = upOnly && (pending == SUB_MAX);
    strobes.stepDown = downOnly && (pending == SUB_MIN);
    pendingNext = pending;
    if (strobes.stepUp || strobes.stepDown) begin
      pendingNext = '0;
    end else if (upOnly) begin
      pendingNext = pending + SUB_ONE;
    end else if (downOnly) begin
      pendingNext = pending - SUB_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else     pending <= pendingNext;
  end

  // R8
  both_pulses_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (incPulse && decPulse) |=> $stable(pending));

  // R5
  down_undoes_up_chk: assert property (@(posedge clk) disable iff (rst)
    (downOnly && pending > SUB_MIN) |=> (pending == $past(pending) - SUB_ONE));

  // R4
  tally_range_chk: assert property (@(posedge clk) disable iff (rst)
    (pending <= SUB_MAX) && (pending >= SUB_MIN));

  // R9
  idle_holds_tally_chk: assert property (@(posedge clk) disable iff (rst)
    (!incPulse && !decPulse) |=> $stable(pending));
endmodule

// File: rtl/detent_counter_dp.sv
module detent_counter_dp
  import detent_counter_pkg::*;
#(
  parameter int COUNT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  stepStrobes_t       strobes,
  output logic [COUNT_W-1:0] count
);
  localparam logic [COUNT_W-1:0] STEP_ONE = COUNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)                  count <= '0;
    else if (strobes.stepUp)   count <= count + STEP_ONE;
    else if (strobes.stepDown) count <= count - STEP_ONE;
  end

  // R2 R6
  step_up_wraps_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.stepUp |=> (count == $past(count) + STEP_ONE));

  // R3 R7
  step_down_wraps_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.stepDown |=> (count == $past(count) - STEP_ONE));

  // R4
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(strobes.stepUp || strobes.stepDown) |=> $stable(count));

  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.stepUp, strobes.stepDown}));
endmodule

// File: rtl/detent_counter.sv
module detent_counter
  import detent_counter_pkg::*;
#(
  parameter int COUNT_W         = 4,
  parameter int PULSES_PER_STEP = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               incPulse,
  input  logic               decPulse,
  output logic [COUNT_W-1:0] count
);
  stepStrobes_t strobes;

  detent_counter_ctrl #(.PULSES_PER_STEP(PULSES_PER_STEP)) ctrl (
    .clk(clk), .rst(rst), .incPulse(incPulse), .decPulse(decPulse),
    .strobes(strobes)
  );

  detent_counter_dp #(.COUNT_W(COUNT_W)) dp (
    .clk(clk), .rst(rst), .strobes(strobes), .count(count)
  );
endmodule

// File: tb/detent_counter_test.sv
module detent_counter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic incPulse = 1'b0;
  logic decPulse = 1'b0;
  logic [3:0] count;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  detent_counter uut (
    .clk(clk), .rst(rst), .incPulse(incPulse), .decPulse(decPulse), .count(count)
  );

  task automatic check(input string req, input logic [3:0] expected);
    checks++;
    if (count !== expected) begin
      fails++;
      $display("FAIL %s: count=%0d expected=%0d", req, count, expected);
    end
  endtask

  task automatic pulse(input logic up, input logic down, input int gap);
    @(negedge clk);
    incPulse = up;
    decPulse = down;
    @(negedge clk);
    incPulse = 1'b0;
    decPulse = 1'b0;
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check("R1", 4'd0);
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0, 0);
    check("R1", 4'd0);
    pulse(1'b1, 1'b0, 0);
    check("R1", 4'd1);
  endtask

  task automatic testUp();
    doReset();
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0, 0);
    check("R4", 4'd0);
    pulse(1'b1, 1'b0, 0);
    check("R2", 4'd1);
    for (int i = 0; i < 4; i++) pulse(1'b1, 1'b0, 0);
    check("R2", 4'd2);
  endtask

  task automatic testDown();
    doReset();
    for (int i = 0; i < 8; i++) pulse(1'b1, 1'b0, 0);
    check("R2", 4'd2);
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1, 0);
    check("R4", 4'd2);
    pulse(1'b0, 1'b1, 0);
    check("R3", 4'd1);
  endtask

  task automatic testCancel();
    doReset();
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0, 0);
    pulse(1'b0, 1'b1, 0);
    pulse(1'b1, 1'b0, 0);
    check("R5", 4'd0);
    pulse(1'b1, 1'b0, 0);
    check("R5", 4'd1);
  endtask

  task automatic testWrapUp();
    doReset();
    for (int i = 0; i < 60; i++) pulse(1'b1, 1'b0, 0);
    check("R6", 4'd15);
    for (int i = 0; i < 4; i++) pulse(1'b1, 1'b0, 0);
    check("R6", 4'd0);
  endtask

  task automatic testWrapDown();
    doReset();
    for (int i = 0; i < 4; i++) pulse(1'b0, 1'b1, 0);
    check("R7", 4'd15);
  endtask

  task automatic testBoth();
    doReset();
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0, 0);
    pulse(1'b1, 1'b1, 0);
    check("R8", 4'd0);
    pulse(1'b1, 1'b0, 0);
    check("R8", 4'd1);
  endtask

  task automatic testGaps();
    doReset();
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1, 5);
    check("R9", 4'd0);
    pulse(1'b0, 1'b1, 0);
    check("R9", 4'd15);
  endtask

  task automatic testMidReset();
    doReset();
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0, 0);
    doReset();
    pulse(1'b1, 1'b0, 0);
    check("R10", 4'd0);
    for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0, 0);
    check("R10", 4'd1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testUp();
    testDown();
    testCancel();
    testWrapUp();
    testWrapDown();
    testBoth();
    testGaps();
    testMidReset();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, count=%0d expected=done", count);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule